// File: doc/BRIEF.md
# Horizontal Eight-Tap Pixel Interpolator

This block filters a stream of 8-bit pixels along one image row. Each output pixel is a weighted sum of eight neighbouring input pixels: three before the output position, the pixel at it, and four after it. The weights are eight signed 16-bit coefficients latched on a load strobe before a block starts. The sum is rounded, scaled down by 128 and clamped to the 8-bit range.

Pixels enter one row at a time on a valid/ready stream, with a flag on the last pixel of each row. The caller pads the row edges itself, so a row of N input pixels yields N-7 outputs. Filtered pixels leave on a second valid/ready stream that carries its own end-of-row flag. The block supports only a unit step. A step code other than 16 (sixteenths of a pixel), sampled with the coefficients, raises an error flag and mutes the output.

Top module: `row_interp8`

## Requirements
- R1: After reset `outValid` and `stepErr` are 0 and `inReady` is 1.
- R2: The output for window position x is clamp((sum over k of c[k]*p[x-3+k] + 64) >>> 7), where tap k is `coefIn[16k+15:16k]` and tap 0 weights the oldest pixel of the window.
- R3: Input pixels are treated as unsigned (zero-extended), so a pixel of 255 times a weight of 128 at tap 3 gives 255.
- R4: Rounding adds 64 before the arithmetic shift by 7, so a weighted sum of 63 gives 0 and a weighted sum of 64 gives 1.
- R5: A negative scaled result outputs 0, and a scaled result above 255 outputs 255.
- R6: The first 7 accepted pixels of a row produce no output. Each later pixel produces exactly one output, in order. A row of 7 or fewer pixels produces none.
- R7: The pixel accepted with `inLast`=1 ends the row, and the next row primes afresh with no pixels carried over. The output produced by that last pixel carries `outLast`=1, and all other outputs carry 0.
- R8: `coefLoad` samples `stepIn`. A value other than 16 sets `stepErr`, and while `stepErr` is set, accepted pixels produce no output. A load with 16 clears `stepErr`.
- R9: Coefficients change only on `coefLoad`. Changes on `coefIn` at other times have no effect on outputs.
- R10: While `outValid`=1 and `outReady`=0, `outPix` and `outLast` hold and no input pixel is lost.
- R11: `coefLoad` may be asserted only between rows, when no pixel of a row has been taken yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coefLoad | input | 1 | Strobe latching coefficients and step code |
| coefIn | input | 128 | Eight packed signed 16-bit weights, tap 0 in the low bits |
| stepIn | input | 5 | Step code in sixteenths of a pixel |
| stepErr | output | 1 | Unsupported step was loaded |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block accepts an input pixel |
| inPix | input | 8 | Input pixel |
| inLast | input | 1 | Input pixel is the last one of its row |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the output pixel |
| outPix | output | 8 | Filtered pixel |
| outLast | output | 1 | Output pixel is the last one of its row |

## Verification
A wrong priming count would show on the first row as one output too many or too few, right after the seventh or eighth pixel. A wrong tap order or a coefficient latched at the wrong time would corrupt the very next output of an asymmetric filter. A stalled pipeline that drops or overwrites its holding stage would show within one cycle of the first back-pressure stall, as a changed held pixel or a missing value in the output order. Errors in rounding and clamping show on single outputs chosen to sit exactly at the rounding and saturation thresholds.

// File: rtl/row_interp8_pkg.sv
package row_interp8_pkg;
  typedef struct packed {
    logic coefLd;   // latch new weights
    logic shiftEn;  // advance the pixel window
    logic capture;  // register a filtered result
  } interp_ctl_t;
endpackage

// File: rtl/row_interp8_ctrl.sv
module row_interp8_ctrl
  import row_interp8_pkg::*;
#(
  parameter int TAPS      = 8,
  parameter int STEP_W    = 5,
  parameter int UNIT_STEP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefLoad,
  input  logic [STEP_W-1:0] stepIn,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              outReady,
  output logic              stepErr,
  output logic              inReady,
  output logic              outValid,
  output logic              outLast,
  output interp_ctl_t       ctl
);
  localparam int CNT_W = $clog2(TAPS);
  localparam logic [CNT_W-1:0] PRIMED = CNT_W'(TAPS - 1);

  logic [CNT_W-1:0] primeCnt;
  logic aValid, aLast, errQ, oValid, oLast;
  logic advOut, advWin, inAccept;

  assign advOut   = !oValid || outReady;
  assign advWin   = !aValid || advOut;
  assign inAccept = inValid && advWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primeCnt <= '0;
      aValid   <= 1'b0;
      aLast    <= 1'b0;
      errQ     <= 1'b0;
      oValid   <= 1'b0;
      oLast    <= 1'b0;
    end else begin
      if (coefLoad) errQ <= (stepIn != STEP_W'(UNIT_STEP));
      if (inAccept) begin
        if (inLast)                primeCnt <= '0;
        else if (primeCnt != PRIMED) primeCnt <= primeCnt + 1'b1;
      end
      if (advWin) begin
        aValid <= inAccept && (primeCnt == PRIMED) && !errQ;
        aLast  <= inLast;
      end
      if (advOut) begin
        oValid <= aValid;
        oLast  <= aLast;
      end
    end
  end

  assign stepErr     = errQ;
  assign inReady     = advWin;
  assign outValid    = oValid;
  assign outLast     = oLast;
  assign ctl.coefLd  = coefLoad;
  assign ctl.shiftEn = inAccept;
  assign ctl.capture = advOut && aValid;

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    coefLoad && (stepIn != STEP_W'(UNIT_STEP)) |=> stepErr); // R8
  AST_ERR_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    stepErr && inValid && inReady |=> !aValid); // R8
  AST_COEF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    coefLoad |-> primeCnt == '0); // R11
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    aValid && outValid && !outReady |-> !inReady); // R10
  AST_SHORT_ROW: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inLast && (primeCnt != PRIMED) |=> !aValid); // R6
endmodule

// File: rtl/row_interp8_dp.sv
module row_interp8_dp
  import row_interp8_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int SHIFT  = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  interp_ctl_t              ctl,
  input  logic [TAPS*COEF_W-1:0]   coefIn,
  input  logic [PIX_W-1:0]         inPix,
  output logic [PIX_W-1:0]         outPix
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);
  localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'((1 << PIX_W) - 1);

  logic        [PIX_W-1:0]  win  [TAPS];
  logic signed [COEF_W-1:0] coef [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0]  acc, scaled;
  logic        [PIX_W-1:0]  clipped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) begin
        win[i]  <= '0;
        coef[i] <= '0;
      end
    end else begin
      if (ctl.coefLd)
        for (int i = 0; i < TAPS; i++) coef[i] <= coefIn[i*COEF_W +: COEF_W];
      if (ctl.shiftEn) begin
        for (int i = 0; i < TAPS - 1; i++) win[i] <= win[i+1];
        win[TAPS-1] <= inPix;
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod[k] = PROD_W'($signed({1'b0, win[k]})) * PROD_W'(coef[k]);
  end

  always_comb begin
    acc = ROUND;
    for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
    scaled = acc >>> SHIFT;
    if (scaled < 0)          clipped = '0;
    else if (scaled > MAX_S) clipped = '1;
    else                     clipped = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outPix <= '0;
    else if (ctl.capture) outPix <= clipped;
  end
endmodule

// File: rtl/row_interp8.sv
module row_interp8
  import row_interp8_pkg::*;
#(
  parameter int TAPS      = 8,
  parameter int PIX_W     = 8,
  parameter int COEF_W    = 16,
  parameter int SHIFT     = 7,
  parameter int STEP_W    = 5,
  parameter int UNIT_STEP = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coefLoad,
  input  logic [TAPS*COEF_W-1:0] coefIn,
  input  logic [STEP_W-1:0]      stepIn,
  output logic                   stepErr,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [PIX_W-1:0]       inPix,
  input  logic                   inLast,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [PIX_W-1:0]       outPix,
  output logic                   outLast
);
  interp_ctl_t ctl;

  row_interp8_ctrl #(.TAPS(TAPS), .STEP_W(STEP_W), .UNIT_STEP(UNIT_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .stepIn(stepIn),
    .inValid(inValid), .inLast(inLast), .outReady(outReady),
    .stepErr(stepErr), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .ctl(ctl)
  );

  row_interp8_dp #(.TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .SHIFT(SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .coefIn(coefIn),
    .inPix(inPix), .outPix(outPix)
  );

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPix) && $stable(outLast)); // R10
endmodule

// File: tb/row_interp8_bench.sv
module row_interp8_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         coefLoad = 1'b0;
  logic [127:0] coefIn = '0;
  logic [4:0]   stepIn = 5'd16;
  logic         stepErr;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [7:0]   inPix = '0;
  logic         inLast = 1'b0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [7:0]   outPix;
  logic         outLast;

  row_interp8 u_row_interp8 (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefIn(coefIn), .stepIn(stepIn),
    .stepErr(stepErr), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outPix(outPix),
    .outLast(outLast)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0, rxCount = 0, cyc = 0;
  string curReq = "R2";
  int expPixQ[$];
  bit expLastQ[$];
  int coefs[8];
  int modelCoef[8];
  bit modelErr = 0;
  int rowBuf[64];
  bit bpOn = 0;
  bit prevStall = 0;
  logic [7:0] prevPix = '0;
  logic prevLast = 1'b0;

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model(int base);
    int s = 0;
    for (int k = 0; k < 8; k++) s += modelCoef[k] * rowBuf[base + k];
    s = (s + 64) >>> 7;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  // back-pressure pattern
  always @(negedge clk) begin
    cyc++;
    outReady = bpOn ? ((cyc % 3) != 0) : 1'b1;
  end

  // output monitor, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (prevStall) begin
        check(outValid && outPix == prevPix && outLast == prevLast, "R10",
              int'(outPix), int'(prevPix), "held output");
      end
      prevStall = outValid && !outReady;
      prevPix   = outPix;
      prevLast  = outLast;
      if (outValid && outReady) begin
        rxCount++;
        if (expPixQ.size() == 0) begin
          check(0, curReq, int'(outPix), -1, "unexpected output");
        end else begin
          int ep;
          bit el;
          ep = expPixQ.pop_front();
          el = expLastQ.pop_front();
          check(int'(outPix) == ep, curReq, int'(outPix), ep, "pixel value");
          check(outLast == el, "R7", int'(outLast), int'(el), "row end flag");
        end
      end
    end
  end

  task automatic loadCoefs(int step, bit latch = 1);
    @(negedge clk);
    for (int k = 0; k < 8; k++) coefIn[k*16 +: 16] = 16'(coefs[k]);
    stepIn = 5'(step);
    coefLoad = latch;
    @(negedge clk);
    coefLoad = 1'b0;
    if (latch) begin
      modelErr = (step != 16);
      for (int k = 0; k < 8; k++) modelCoef[k] = coefs[k];
    end
  endtask

  task automatic pushPix(int p, bit last);
    inPix = 8'(p);
    inLast = last;
    inValid = 1'b1;
    forever begin
      #1;
      if (inReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic sendRow(int n);
    if (!modelErr)
      for (int i = 7; i < n; i++) begin
        expPixQ.push_back(model(i - 7));
        expLastQ.push_back(i == n - 1);
      end
    @(negedge clk);
    for (int i = 0; i < n; i++) pushPix(rowBuf[i], i == n - 1);
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 2000 && expPixQ.size() != 0; g++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic expectCount(int base, int n, string req);
    check(rxCount - base == n, req, rxCount - base, n, "output count");
  endtask

  task automatic setCoefs(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
    coefs[0] = c0; coefs[1] = c1; coefs[2] = c2; coefs[3] = c3;
    coefs[4] = c4; coefs[5] = c5; coefs[6] = c6; coefs[7] = c7;
  endtask

  task automatic tReset();
    curReq = "R1";
    #2;
    check(outValid == 1'b0, "R1", int'(outValid), 0, "outValid after reset");
    check(stepErr == 1'b0, "R1", int'(stepErr), 0, "stepErr after reset");
    check(inReady == 1'b1, "R1", int'(inReady), 1, "inReady after reset");
  endtask

  task automatic tIdentity();
    int base = rxCount;
    curReq = "R3";
    setCoefs(0, 0, 0, 128, 0, 0, 0, 0);
    loadCoefs(16);
    for (int i = 0; i < 16; i++) rowBuf[i] = (i * 37 + 200) % 256;
    rowBuf[5] = 255; rowBuf[6] = 200; rowBuf[9] = 0;
    sendRow(16);
    drain();
    expectCount(base, 9, "R6");
  endtask

  task automatic tAsym();
    int base = rxCount;
    curReq = "R2";
    setCoefs(-1, 3, -10, 70, 60, -8, 12, 2);
    loadCoefs(16);
    for (int i = 0; i < 20; i++) rowBuf[i] = (i * 71 + 13) % 256;
    sendRow(20);
    drain();
    expectCount(base, 13, "R6");
  endtask

  task automatic tRound();
    curReq = "R4";
    setCoefs(0, 0, 0, 1, 0, 0, 0, 0);
    loadCoefs(16);
    for (int i = 0; i < 16; i++) rowBuf[i] = 0;
    rowBuf[3] = 63; rowBuf[4] = 64; rowBuf[5] = 65; rowBuf[6] = 127;
    rowBuf[7] = 128; rowBuf[8] = 191; rowBuf[9] = 192;
    sendRow(17);
    drain();
  endtask

  task automatic tSaturate();
    curReq = "R5";
    setCoefs(0, 0, 0, 256, 0, 0, 0, 0);
    loadCoefs(16);
    for (int i = 0; i < 12; i++) rowBuf[i] = 200 - i * 10;
    sendRow(12);
    drain();
    setCoefs(0, 0, 0, -128, 0, 0, 0, 0);
    loadCoefs(16);
    sendRow(12);
    drain();
    setCoefs(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767);
    loadCoefs(16);
    for (int i = 0; i < 10; i++) rowBuf[i] = 255;
    sendRow(10);
    drain();
  endtask

  task automatic tShortRows();
    int base;
    curReq = "R6";
    setCoefs(2, 4, 8, 50, 50, 8, 4, 2);
    loadCoefs(16);
    base = rxCount;
    for (int i = 0; i < 8; i++) rowBuf[i] = 250;
    sendRow(5);
    drain();
    expectCount(base, 0, "R6");
    base = rxCount;
    curReq = "R7";
    for (int i = 0; i < 8; i++) rowBuf[i] = i * 20;
    sendRow(8);
    drain();
    expectCount(base, 1, "R7");
    base = rxCount;
    sendRow(7);
    drain();
    expectCount(base, 0, "R6");
  endtask

  task automatic tStep();
    int base;
    curReq = "R8";
    setCoefs(0, 0, 0, 128, 0, 0, 0, 0);
    loadCoefs(8);
    #2;
    check(stepErr == 1'b1, "R8", int'(stepErr), 1, "stepErr on step 8");
    base = rxCount;
    for (int i = 0; i < 12; i++) rowBuf[i] = i + 40;
    sendRow(12);
    drain();
    expectCount(base, 0, "R8");
    loadCoefs(16);
    #2;
    check(stepErr == 1'b0, "R8", int'(stepErr), 0, "stepErr cleared");
    base = rxCount;
    sendRow(12);
    drain();
    expectCount(base, 5, "R8");
  endtask

  task automatic tCoefHold();
    curReq = "R9";
    setCoefs(10, 20, 30, 40, 10, 10, 5, 3);
    loadCoefs(16);
    setCoefs(0, 0, 0, -128, 0, 0, 0, 0);
    loadCoefs(16, 0);  // new value on coefIn, no strobe
    for (int i = 0; i < 14; i++) rowBuf[i] = (i * 53 + 7) % 256;
    sendRow(14);
    drain();
  endtask

  task automatic tBackpressure();
    int base = rxCount;
    curReq = "R10";
    setCoefs(-3, 9, -20, 90, 50, -12, 10, 4);
    loadCoefs(16);
    bpOn = 1;
    for (int i = 0; i < 30; i++) rowBuf[i] = (i * 97 + 31) % 256;
    sendRow(30);
    sendRow(9);
    drain();
    bpOn = 0;
    expectCount(base, 25, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdentity();
    tAsym();
    tRound();
    tSaturate();
    tShortRows();
    tStep();
    tCoefHold();
    tBackpressure();
    check(expPixQ.size() == 0, "R6", expPixQ.size(), 0, "outputs still pending");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion (%s)", curReq);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule